// File: doc/BRIEF.md
# SIMT Branch Divergence Stack

This block is the divergence control for one warp of 32 threads. It keeps the set of threads that execute the current instruction as a lane mask, and it works out the program counter of the next instruction. When a conditional branch splits the active threads, it runs the taken group first and parks the other group on a small hardware stack. A second stack frame holds the mask from before the split, so that the full group rejoins at the reconvergence address once both groups have reached it.

Each cycle the issue logic presents the PC of the instruction being issued. When that instruction is a branch, it also presents the per-thread taken bits and the three addresses that matter: the target, the fall-through and the join point. The block returns the PC to fetch next. The new mask is registered and takes effect with that next instruction. Every warp gets its own instance, so divergence in one warp has no effect on any other warp. Threads outside the active mask are never re-enabled by a branch. They come back only when a stack frame is restored.

Top module: `simt_div_stack`

## Requirements
- R1: After reset the mask is all ones (all 32 threads), the overflow flag is 0 and the stack is empty.
- R2: In a cycle with no branch and no reconvergence match, next_pc is cur_pc + 1 and the mask does not change. While the stack is empty, no cur_pc value causes a match.
- R3: A branch that every active thread takes sets next_pc to the target. It leaves the mask unchanged and pushes nothing. Taken bits of inactive threads are ignored.
- R4: A branch that no active thread takes sets next_pc to the fall-through address. It leaves the mask unchanged and pushes nothing.
- R5: A branch that splits the active threads and finds at least two free frames does four things. It sets next_pc to the target, narrows the mask to active AND taken, pushes a join frame (the old mask, resume at the join PC), and then pushes a frame for the other group (active AND NOT taken, resume at the fall-through, same join PC).
- R6: When cur_pc equals the join PC of the top frame, that frame is popped. next_pc becomes its resume PC and the mask becomes its mask, so the group that did not take the branch runs next.
- R7: When the not-taken group also reaches the join PC, the join frame is popped. The mask returns to its value before the split and next_pc is the join PC. This holds even when the fall-through equals the join PC.
- R8: A split inside an already divided path divides only the currently active mask. Frames are restored last-in first-out.
- R9: When a branch arrives in the same cycle as a reconvergence match, the pop takes effect and the branch is ignored.
- R10: A splitting branch that finds fewer than two free frames (stack depth 8) pushes nothing and keeps the mask. It returns next_pc = cur_pc and sets the overflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | The instruction at cur_pc is a conditional branch |
| br_taken | input | 32 | Per-thread branch outcome, 1 = taken |
| br_target | input | 32 | Branch target PC |
| br_fallthru | input | 32 | PC after the branch when it is not taken |
| br_reconv | input | 32 | PC where the two paths rejoin |
| cur_pc | input | 32 | PC of the instruction issued this cycle |
| active_mask | output | 32 | Threads enabled for the current instruction |
| next_pc | output | 32 | PC to fetch next (combinational) |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
A reconvergence pop and a branch can both fall on the same cycle. This happens when the instruction that sits at a join address is itself a branch. The bench provokes it by issuing a splitting branch at the inner join PC while a nested divergence is still open. The result is judged at the ports: next_pc must be the resume PC of the popped frame and not the branch target, and the registered mask must equal the parked mask, not a subset of it. The next reconvergence steps in the same run then confirm that the ignored branch left no frames behind.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
    parameter int SIMT_LANES = 32;
    parameter int SIMT_PC_W  = 32;

    typedef logic [SIMT_LANES-1:0] lane_mask_t;
    typedef logic [SIMT_PC_W-1:0]  pc_t;

    // One parked context: which threads, where they resume, where they rejoin
    typedef struct packed {
        lane_mask_t mask;
        pc_t        resume_pc;
        pc_t        join_pc;
    } frame_t;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
    import simt_div_pkg::*;
(
    input  lane_mask_t active,
    input  lane_mask_t taken,
    output lane_mask_t on_path,
    output lane_mask_t off_path,
    output logic       all_take,
    output logic       none_take
);
    always_comb begin
        on_path   = active & taken;
        off_path  = active & ~taken;
        all_take  = (off_path == '0);
        none_take = (on_path == '0);
    end
endmodule

// File: rtl/simt_frame_store.sv
module simt_frame_store
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [SP_W-1:0] base,
    input  frame_t          lo_frame,
    input  frame_t          hi_frame,
    input  logic [SP_W-1:0] rd_idx,
    output frame_t          rd_frame
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t slots_q [DEPTH];
    logic [SP_W-1:0] base_p1;

    assign base_p1 = base + 1'b1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [SP_W-1:0] SLOT = SP_W'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots_q[i] <= '0;
            end else if (push_en && base == SLOT) begin
                slots_q[i] <= lo_frame;
            end else if (push_en && base_p1 == SLOT) begin
                slots_q[i] <= hi_frame;
            end
        end
    end

    always_comb begin
        if (rd_idx < SP_W'(DEPTH)) begin
            rd_frame = slots_q[rd_idx[IDX_W-1:0]];
        end else begin
            rd_frame = '0;
        end
    end
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  br_valid,
    input  logic [SIMT_LANES-1:0] br_taken,
    input  logic [SIMT_PC_W-1:0]  br_target,
    input  logic [SIMT_PC_W-1:0]  br_fallthru,
    input  logic [SIMT_PC_W-1:0]  br_reconv,
    input  logic [SIMT_PC_W-1:0]  cur_pc,
    output logic [SIMT_LANES-1:0] active_mask,
    output logic [SIMT_PC_W-1:0]  next_pc,
    output logic                  overflow
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] ROOM_MAX = SP_W'(DEPTH - 2);

    typedef struct packed {
        lane_mask_t      mask;
        logic [SP_W-1:0] sp;
        logic            ovf;
    } ctl_t;

    ctl_t       st_d, st_q;
    frame_t     top_frame, lo_frame, hi_frame;
    lane_mask_t on_path, off_path;
    logic       all_take, none_take, push_en, at_join, has_room;
    pc_t        pc_nx;

    simt_branch_split u_split (
        .active    (st_q.mask),
        .taken     (br_taken),
        .on_path   (on_path),
        .off_path  (off_path),
        .all_take  (all_take),
        .none_take (none_take)
    );

    simt_frame_store #(.DEPTH(DEPTH), .SP_W(SP_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .base     (st_q.sp),
        .lo_frame (lo_frame),
        .hi_frame (hi_frame),
        .rd_idx   (st_q.sp - 1'b1),
        .rd_frame (top_frame)
    );

    assign at_join  = (st_q.sp != '0) && (cur_pc == top_frame.join_pc);
    assign has_room = (st_q.sp <= ROOM_MAX);

    // Join frame goes below, the other group's frame on top of it
    assign lo_frame = '{mask: st_q.mask, resume_pc: br_reconv,   join_pc: br_reconv};
    assign hi_frame = '{mask: off_path,  resume_pc: br_fallthru, join_pc: br_reconv};

    always_comb begin
        st_d    = st_q;
        push_en = 1'b0;
        pc_nx   = cur_pc + pc_t'(1);
        if (at_join) begin
            st_d.mask = top_frame.mask;
            st_d.sp   = st_q.sp - 1'b1;
            pc_nx     = top_frame.resume_pc;
        end else if (br_valid) begin
            if (all_take) begin
                pc_nx = br_target;
            end else if (none_take) begin
                pc_nx = br_fallthru;
            end else if (has_room) begin
                push_en   = 1'b1;
                st_d.sp   = st_q.sp + SP_W'(2);
                st_d.mask = on_path;
                pc_nx     = br_target;
            end else begin
                st_d.ovf = 1'b1;
                pc_nx    = cur_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mask: '1, sp: '0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_mask = st_q.mask;
    assign next_pc     = pc_nx;
    assign overflow    = st_q.ovf;
endmodule

// File: rtl/simt_div_stack_chk.sv
module simt_div_stack_chk
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SP_W  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_valid,
    input lane_mask_t      br_taken,
    input pc_t             cur_pc,
    input lane_mask_t      active_mask,
    input pc_t             next_pc,
    input logic            overflow,
    input logic [SP_W-1:0] sp,
    input logic            at_join
);
    logic splits, uniform;
    assign splits  = ((active_mask & br_taken) != '0) && ((active_mask & ~br_taken) != '0);
    assign uniform = !splits;

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);                                           // R5
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !at_join) |-> next_pc == cur_pc + pc_t'(1));    // R2
    AST_UNIFORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !at_join && uniform) |=> $stable(active_mask));  // R3
    AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !at_join && splits && sp <= SP_W'(DEPTH - 2))
        |=> active_mask == $past(active_mask & br_taken));            // R5
    AST_JOIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        at_join |=> (sp + 1'b1) == $past(sp));                        // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                       // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH));                                          // R10
endmodule

bind simt_div_stack simt_div_stack_chk #(.DEPTH(DEPTH), .SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_taken    (br_taken),
    .cur_pc      (cur_pc),
    .active_mask (active_mask),
    .next_pc     (next_pc),
    .overflow    (overflow),
    .sp          (st_q.sp),
    .at_join     (at_join)
);

// File: tb/simt_div_stack_test.sv
`timescale 1ns/1ps
module simt_div_stack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_taken = '0, br_target = '0, br_fallthru = '0, br_reconv = '0, cur_pc = '0;
    logic [31:0] active_mask, next_pc;
    logic        overflow;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    simt_div_stack uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
        .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .cur_pc(cur_pc), .active_mask(active_mask), .next_pc(next_pc), .overflow(overflow)
    );

    typedef struct packed {
        logic        br;
        logic [31:0] tk, tg, ft, rc, cu, en, em;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h10, 32'h11, 32'hFFFFFFFF, 8'd2}, // R2
        '{1'b1, 32'hFFFFFFFF, 32'h40, 32'h12, 32'h50, 32'h11, 32'h40, 32'hFFFFFFFF, 8'd3}, // R3
        '{1'b1, 32'h0,        32'h80, 32'h41, 32'h90, 32'h40, 32'h41, 32'hFFFFFFFF, 8'd4}, // R4
        '{1'b1, 32'h0000FFFF, 32'h60, 32'h42, 32'h70, 32'h41, 32'h60, 32'h0000FFFF, 8'd5}, // R5
        '{1'b1, 32'hF00000FF, 32'h64, 32'h61, 32'h68, 32'h60, 32'h64, 32'h000000FF, 8'd8}, // R8
        '{1'b1, 32'hFFFF00FF, 32'h66, 32'h0,  32'h0,  32'h64, 32'h66, 32'h000000FF, 8'd3}, // R3 inactive bits
        '{1'b1, 32'h0000000F, 32'h99, 32'h9A, 32'h9B, 32'h68, 32'h61, 32'h0000FF00, 8'd9}, // R9
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h61, 32'h62, 32'h0000FF00, 8'd2}, // R2
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h68, 32'h68, 32'h0000FFFF, 8'd8}, // R8
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h68, 32'h69, 32'h0000FFFF, 8'd8}, // R8
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h70, 32'h42, 32'hFFFF0000, 8'd6}, // R6
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h42, 32'h43, 32'hFFFF0000, 8'd2}, // R2
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h70, 32'h70, 32'hFFFFFFFF, 8'd7}, // R7
        '{1'b0, 32'h0,        32'h0,  32'h0,  32'h0,  32'h70, 32'h71, 32'hFFFFFFFF, 8'd2}  // R2
    };

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic b, input logic [31:0] tk, tg, ft, rc, cu, en, em, input string rq);
        @(negedge clk);
        br_valid = b; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc; cur_pc = cu;
        #1 check(rq, "next_pc", next_pc, en);
        @(posedge clk);
        #1 check(rq, "active_mask", active_mask, em);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; br_valid = 1'b0; br_taken = '0; cur_pc = 32'h0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "active_mask", active_mask, 32'hFFFFFFFF);
        check("R1", "overflow", {31'b0, overflow}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].br, VECS[i].tk, VECS[i].tg, VECS[i].ft, VECS[i].rc, VECS[i].cu,
                VECS[i].en, VECS[i].em, $sformatf("R%0d", VECS[i].rq));
        end

        // R7: fall-through coincides with the join PC
        run(1'b1, 32'hFFFF0000, 32'h30, 32'h25, 32'h25, 32'h20, 32'h30, 32'hFFFF0000, "R5");
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h30, 32'h31, 32'hFFFF0000, "R2");
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h25, 32'h25, 32'h0000FFFF, "R6");
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h25, 32'h25, 32'hFFFFFFFF, "R7");
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h25, 32'h26, 32'hFFFFFFFF, "R2");

        // R10: fill all eight frames, then one more split
        run(1'b1, 32'h0000FFFF, 32'h180, 32'h101, 32'h1F0, 32'h100, 32'h180, 32'h0000FFFF, "R8");
        run(1'b1, 32'h000000FF, 32'h181, 32'h102, 32'h1EF, 32'h101, 32'h181, 32'h000000FF, "R8");
        run(1'b1, 32'h0000000F, 32'h182, 32'h103, 32'h1EE, 32'h102, 32'h182, 32'h0000000F, "R8");
        run(1'b1, 32'h00000003, 32'h183, 32'h104, 32'h1ED, 32'h103, 32'h183, 32'h00000003, "R8");
        check("R10", "overflow before full push", {31'b0, overflow}, 32'h0);
        run(1'b1, 32'h00000001, 32'h184, 32'h105, 32'h1EC, 32'h104, 32'h104, 32'h00000003, "R10");
        check("R10", "overflow", {31'b0, overflow}, 32'h1);
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h105, 32'h106, 32'h00000003, "R10");
        check("R10", "overflow sticky", {31'b0, overflow}, 32'h1);

        // R1: reset clears overflow and restores the full mask
        do_reset();
        #1;
        check("R1", "active_mask", active_mask, 32'hFFFFFFFF);
        check("R1", "overflow", {31'b0, overflow}, 32'h0);
        run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1ED, 32'h1EE, 32'hFFFFFFFF, "R1");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule